// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of binary token flags that two independent ports share. Each port can claim a flag by writing 0 to it and give it back by writing 1. Each port can also read the flag to find out whether it holds the token. Two processors use it to guard a shared resource without any software lock protocol. Each port keeps its own request latch for every flag. A request that loses stays pending and receives the token as soon as the owner lets it go.

A read returns the flag as seen from the reading side, copied onto every bit of the read bus. The value is captured when the read access begins and stays frozen until the select or the output enable drops. A port that polls therefore has to end its access and start a new one to see a change. All strobes are sampled on the rising clock edge. Ownership changes in the cycle after the write is sampled.

Top module: `twoPortSemBank`

## Requirements
- R1: The three lowest address bits select one of eight flags. Every higher address bit is ignored.
- R2: After reset every flag is free, and both ports read 8'hFF from every flag.
- R3: A write is sampled when select and write strobe are both high. A write bit of 0 sets the port's request, a write bit of 1 clears it, and a write strobe without select has no effect.
- R4: When a port writes 0 to a free flag, that port reads 8'h00 from the flag and the other port reads 8'hFF.
- R5: A 0 written by the port that does not own the flag is held as a pending request and leaves the visible flag unchanged on both sides.
- R6: When the owner writes 1 and the other port has a pending request, ownership passes straight to the other port. If no request is pending, the flag becomes free and both sides read 8'hFF.
- R7: Read data is the flag value replicated on all eight bits, so it is always 8'h00 or 8'hFF.
- R8: A read access is select and output enable high with the write strobe low. Its value is captured in the first sampled cycle of the access and held until select or output enable goes low.
- R9: If both ports request the same free flag in the same cycle, the left port gets the token and the right request stays pending.
- R10: While a port has no read access in progress, its read data is 8'h00.
- R11: The flags are independent. Activity on one flag never changes the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lfSel | input | 1 | Left semaphore select |
| lfWe | input | 1 | Left write strobe |
| lfOe | input | 1 | Left output enable |
| lfAddr | input | ADDR_W | Left address; only the low bits pick the flag |
| lfWrBit | input | 1 | Left write datum (0 request, 1 release) |
| lfRdData | output | DATA_W | Left read data |
| rtSel | input | 1 | Right semaphore select |
| rtWe | input | 1 | Right write strobe |
| rtOe | input | 1 | Right output enable |
| rtAddr | input | ADDR_W | Right address; only the low bits pick the flag |
| rtWrBit | input | 1 | Right write datum (0 request, 1 release) |
| rtRdData | output | DATA_W | Right read data |

## Verification
A lost or stuck request latch shows up only later, when the owner releases the flag. The bench therefore runs full procurement sequences and reads both sides after each handoff. A wrong owner state shows up on the next read that starts after the faulty edge, which is two cycles after the write that caused it. A capture-timing fault shows up as read data changing in the middle of a held access. The bench catches it by keeping one read open across an ownership change and sampling it on several cycles.

// File: rtl/semPkg.sv
package semPkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } ownState_t;

  // index 0 = left port, index 1 = right port
  typedef struct packed {
    logic [1:0] wrEn;
    logic [1:0] wrVal;
    logic [1:0] capture;
    logic [1:0] readOn;
  } semStrobes_t;

endpackage

// File: rtl/semCtrl.sv
module semCtrl
  import semPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  sel,
  input  logic [1:0]  we,
  input  logic [1:0]  oe,
  input  logic [1:0]  wrBit,
  output semStrobes_t stb
);

  logic [1:0] rdNow;
  logic [1:0] rdPrev;

  for (genvar p = 0; p < 2; p++) begin : g_port
    assign rdNow[p]       = sel[p] && oe[p] && !we[p];
    assign stb.wrEn[p]    = sel[p] && we[p];
    assign stb.wrVal[p]   = wrBit[p];
    assign stb.capture[p] = rdNow[p] && !rdPrev[p];
    assign stb.readOn[p]  = rdPrev[p];

    always_ff @(posedge clk) begin
      if (!rstN) rdPrev[p] <= 1'b0;
      else       rdPrev[p] <= rdNow[p];
    end
  end

endmodule

// File: rtl/semDatapath.sv
module semDatapath
  import semPkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  semStrobes_t       stb,
  input  logic [IDX_W-1:0]  lfIdx,
  input  logic [IDX_W-1:0]  rtIdx,
  output logic [DATA_W-1:0] lfRdData,
  output logic [DATA_W-1:0] rtRdData
);

  logic [NUM_FLAGS-1:0] reqL, reqR;   // 1 = idle, 0 = requesting
  logic [NUM_FLAGS-1:0] visL, visR;   // flag as seen from each side
  ownState_t            own [NUM_FLAGS];
  logic [DATA_W-1:0]    holdL, holdR;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic      hitL, hitR, nReqL, nReqR;
    ownState_t nxtOwn;

    assign hitL  = stb.wrEn[0] && (lfIdx == IDX_W'(i));
    assign hitR  = stb.wrEn[1] && (rtIdx == IDX_W'(i));
    assign nReqL = hitL ? stb.wrVal[0] : reqL[i];
    assign nReqR = hitR ? stb.wrVal[1] : reqR[i];

    always_comb begin
      nxtOwn = own[i];
      case (own[i])
        OWN_LEFT:  if (nReqL) nxtOwn = nReqR ? OWN_NONE : OWN_RIGHT;
        OWN_RIGHT: if (nReqR) nxtOwn = nReqL ? OWN_NONE : OWN_LEFT;
        default: begin
          if (!nReqL)      nxtOwn = OWN_LEFT;
          else if (!nReqR) nxtOwn = OWN_RIGHT;
          else             nxtOwn = OWN_NONE;
        end
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqL[i] <= 1'b1;
        reqR[i] <= 1'b1;
        own[i]  <= OWN_NONE;
      end else begin
        reqL[i] <= nReqL;
        reqR[i] <= nReqR;
        own[i]  <= nxtOwn;
      end
    end

    assign visL[i] = (own[i] != OWN_LEFT);
    assign visR[i] = (own[i] != OWN_RIGHT);

    AST_FREE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      own[i] == OWN_NONE |-> (reqL[i] && reqR[i])); // R6

    AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (own[i] == OWN_LEFT && !(hitL && stb.wrVal[0])) |=> own[i] == OWN_LEFT); // R5

    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rstN)
      (own[i] == OWN_LEFT && hitL && stb.wrVal[0] && !reqR[i] && !(hitR && stb.wrVal[1]))
      |=> own[i] == OWN_RIGHT); // R6

    AST_LEFT_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
      (own[i] == OWN_NONE && hitL && !stb.wrVal[0] && hitR && !stb.wrVal[1])
      |=> own[i] == OWN_LEFT); // R9
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdL <= '0;
      holdR <= '0;
    end else begin
      if (stb.capture[0]) holdL <= {DATA_W{visL[lfIdx]}};
      if (stb.capture[1]) holdR <= {DATA_W{visR[rtIdx]}};
    end
  end

  assign lfRdData = stb.readOn[0] ? holdL : '0;
  assign rtRdData = stb.readOn[1] ? holdR : '0;

  AST_RD_REPLICATED: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(lfRdData) == 0 || $countones(lfRdData) == DATA_W) &&
    ($countones(rtRdData) == 0 || $countones(rtRdData) == DATA_W)); // R7

  AST_RD_FROZEN_L: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readOn[0] && !stb.capture[0]) |=> (!stb.readOn[0] || $stable(lfRdData))); // R8

  AST_RD_FROZEN_R: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readOn[1] && !stb.capture[1]) |=> (!stb.readOn[1] || $stable(rtRdData))); // R8

endmodule

// File: rtl/twoPortSemBank.sv
module twoPortSemBank
  import semPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lfSel,
  input  logic              lfWe,
  input  logic              lfOe,
  input  logic [ADDR_W-1:0] lfAddr,
  input  logic              lfWrBit,
  output logic [DATA_W-1:0] lfRdData,
  input  logic              rtSel,
  input  logic              rtWe,
  input  logic              rtOe,
  input  logic [ADDR_W-1:0] rtAddr,
  input  logic              rtWrBit,
  output logic [DATA_W-1:0] rtRdData
);

  localparam int IDX_W = $clog2(NUM_FLAGS);

  semStrobes_t stb;
  logic        unusedAddrHi;

  assign unusedAddrHi = ^{lfAddr[ADDR_W-1:IDX_W], rtAddr[ADDR_W-1:IDX_W]};

  semCtrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .sel   ({rtSel, lfSel}),
    .we    ({rtWe, lfWe}),
    .oe    ({rtOe, lfOe}),
    .wrBit ({rtWrBit, lfWrBit}),
    .stb   (stb)
  );

  semDatapath #(
    .NUM_FLAGS (NUM_FLAGS),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .lfIdx    (lfAddr[IDX_W-1:0]),
    .rtIdx    (rtAddr[IDX_W-1:0]),
    .lfRdData (lfRdData),
    .rtRdData (rtRdData)
  );

endmodule

// File: tb/twoPortSemBank_test.sv
module twoPortSemBank_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lfSel = 0, lfWe = 0, lfOe = 0, lfWrBit = 0;
  logic        rtSel = 0, rtWe = 0, rtOe = 0, rtWrBit = 0;
  logic [15:0] lfAddr = '0, rtAddr = '0;
  logic [7:0]  lfRdData, rtRdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twoPortSemBank uut (
    .clk(clk), .rstN(rstN),
    .lfSel(lfSel), .lfWe(lfWe), .lfOe(lfOe), .lfAddr(lfAddr), .lfWrBit(lfWrBit), .lfRdData(lfRdData),
    .rtSel(rtSel), .rtWe(rtWe), .rtOe(rtOe), .rtAddr(rtAddr), .rtWrBit(rtWrBit), .rtRdData(rtRdData)
  );

  // port: 0 left, 1 right
  typedef struct packed {
    logic        port;
    logic        isWr;
    logic [15:0] addr;
    logic        wbit;
    logic [7:0]  exp;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 16'hABC5, 1'b0, 8'h00},  // R4 left requests free flag 5
    '{1'b0, 1'b0, 16'h0005, 1'b0, 8'h00},  // R4 left owns
    '{1'b1, 1'b0, 16'h7705, 1'b0, 8'hFF},  // R4 right sees taken
    '{1'b1, 1'b1, 16'h0005, 1'b0, 8'h00},  // R5 right request pends
    '{1'b1, 1'b0, 16'h0005, 1'b0, 8'hFF},  // R5 right still not owner
    '{1'b0, 1'b0, 16'h0005, 1'b0, 8'h00},  // R5 left unchanged
    '{1'b0, 1'b1, 16'h0005, 1'b1, 8'h00},  // R6 left releases
    '{1'b1, 1'b0, 16'h0005, 1'b0, 8'h00},  // R6 right received token
    '{1'b0, 1'b0, 16'h0005, 1'b0, 8'hFF},  // R6 left lost token
    '{1'b0, 1'b1, 16'h0005, 1'b0, 8'h00},  // R5 left request pends
    '{1'b1, 1'b1, 16'h0005, 1'b1, 8'h00},  // R6 right releases
    '{1'b0, 1'b0, 16'h0005, 1'b0, 8'h00},  // R6 left received token
    '{1'b0, 1'b1, 16'hFFF5, 1'b1, 8'h00},  // R1 release via high address bits
    '{1'b0, 1'b0, 16'h0005, 1'b0, 8'hFF},  // R6 free again
    '{1'b1, 1'b0, 16'h0005, 1'b0, 8'hFF},  // R6 free on right
    '{1'b0, 1'b0, 16'h0002, 1'b0, 8'hFF},  // R11 other flag untouched
    '{1'b1, 1'b1, 16'h0006, 1'b0, 8'h00},  // R4 right requests flag 6
    '{1'b1, 1'b0, 16'h0006, 1'b0, 8'h00},  // R4 right owns flag 6
    '{1'b0, 1'b0, 16'h0005, 1'b0, 8'hFF},  // R11 flag 5 still free
    '{1'b1, 1'b1, 16'h0006, 1'b1, 8'h00}   // R6 right releases flag 6
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic port, input logic [15:0] addr, input logic wbit);
    @(negedge clk);
    if (!port) begin lfSel = 1; lfWe = 1; lfAddr = addr; lfWrBit = wbit; end
    else       begin rtSel = 1; rtWe = 1; rtAddr = addr; rtWrBit = wbit; end
    @(negedge clk);
    lfSel = 0; lfWe = 0; rtSel = 0; rtWe = 0;
  endtask

  task automatic doRead(input logic port, input logic [15:0] addr, output logic [7:0] val);
    @(negedge clk);
    if (!port) begin lfSel = 1; lfOe = 1; lfAddr = addr; end
    else       begin rtSel = 1; rtOe = 1; rtAddr = addr; end
    @(negedge clk);
    val = port ? rtRdData : lfRdData;
    lfSel = 0; lfOe = 0; rtSel = 0; rtOe = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R10 idle output, R2 reset state
    check("R10 left idle", lfRdData, 8'h00);
    check("R10 right idle", rtRdData, 8'h00);
    for (int f = 0; f < 8; f++) begin
      doRead(1'b0, 16'(f), v); check("R2 left reset", v, 8'hFF);
      doRead(1'b1, 16'(f), v); check("R2 right reset", v, 8'hFF);
    end

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      if (VECS[k].isWr) doWrite(VECS[k].port, VECS[k].addr, VECS[k].wbit);
      else begin
        doRead(VECS[k].port, VECS[k].addr, v);
        check($sformatf("R4/R5/R6/R11 vector %0d", k), v, VECS[k].exp);
      end
    end

    // R3 write strobe without select is ignored
    @(negedge clk); lfWe = 1; lfAddr = 16'h0004; lfWrBit = 0;
    @(negedge clk); lfWe = 0;
    doRead(1'b0, 16'h0004, v); check("R3 unselected write left", v, 8'hFF);
    doRead(1'b1, 16'h0004, v); check("R3 unselected write right", v, 8'hFF);

    // R9 same-cycle requests on flag 3
    @(negedge clk);
    lfSel = 1; lfWe = 1; lfAddr = 16'h0003; lfWrBit = 0;
    rtSel = 1; rtWe = 1; rtAddr = 16'h0003; rtWrBit = 0;
    @(negedge clk);
    lfSel = 0; lfWe = 0; rtSel = 0; rtWe = 0;
    doRead(1'b0, 16'h0003, v); check("R9 left wins", v, 8'h00);
    doRead(1'b1, 16'h0003, v); check("R9 right pending", v, 8'hFF);
    doWrite(1'b0, 16'h0003, 1'b1);
    doRead(1'b1, 16'h0003, v); check("R9 pending right takes token", v, 8'h00);
    doWrite(1'b1, 16'h0003, 1'b1);

    // R8 frozen read across an ownership change on flag 1
    doWrite(1'b0, 16'h0001, 1'b0);
    doWrite(1'b1, 16'h0001, 1'b0);
    @(negedge clk); rtSel = 1; rtOe = 1; rtAddr = 16'h0001;
    @(negedge clk);
    check("R8 right captured", rtRdData, 8'hFF);
    lfSel = 1; lfWe = 1; lfAddr = 16'h0001; lfWrBit = 1;
    @(negedge clk);
    lfSel = 0; lfWe = 0;
    check("R8 held after handoff", rtRdData, 8'hFF);
    @(negedge clk);
    check("R8 still held", rtRdData, 8'hFF);
    rtOe = 0;
    @(negedge clk);
    check("R10 output drops after access", rtRdData, 8'h00);
    rtOe = 1;
    @(negedge clk);
    check("R8 new access sees owner", rtRdData, 8'h00);
    rtSel = 0; rtOe = 0;
    doWrite(1'b1, 16'h0001, 1'b1);
    doRead(1'b0, 16'h0001, v); check("R6 flag 1 free", v, 8'hFF);

    // R7 replication on a read of both values
    doWrite(1'b1, 16'h0007, 1'b0);
    doRead(1'b1, 16'h0007, v); check("R7 all zeros", v, 8'h00);
    doRead(1'b0, 16'h0007, v); check("R7 all ones", v, 8'hFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule